// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block lets two ports that run on unrelated clocks hand single words to each other without going through the bulk queues. Each direction has its own mailbox register. Port A fills the first mailbox (mail1) and Port B empties it. Port B fills the second mailbox (mail2) and Port A empties it. Each mailbox has an active-low full flag. The flag stays low from the moment a word is stored until the far side has read it. While the flag is low, further stores into that mailbox are dropped.

Every port has a read-data output that is driven by a small selector. Its mailbox-select input picks between the mailbox that port reads and the queue output word that arrives on that port's queue input bus. A port that is not enabled for output drives all zeros. Each mailbox sits in the reset scope of the queue that runs in the same direction. When that reset is held low, the mailbox's flag is forced high and its word is cleared. The other mailbox is left as it is.

Each mailbox runs as two small state machines, one in each clock domain. They are linked by toggle signals that pass through synchronizer chains.

The writer machine has two states:
- W_OPEN: the flag is high. A store moves it to W_HELD and flips the store toggle.
- W_HELD: the flag is low. It returns to W_OPEN once the synchronized read toggle matches the store toggle.

The reader machine also has two states:
- R_DRY: no word is pending. It moves to R_LOADED when the synchronized store toggle differs from its own read toggle.
- R_LOADED: a word is pending. A mailbox read flips the read toggle and returns the machine to R_DRY.

Top module: `mailbox_pair`

## Requirements
- R1: At a clk_a rising edge where a_en=1, a_wr=1, a_mbx_sel=1 and mail1_full_n=1, the mail1 word takes a_din and mail1_full_n is 0 after that edge. The mirror case also holds: a clk_b store with b_en=1, b_wr=1, b_mbx_sel=1 loads mail2 from b_din and drives mail2_full_n to 0.
- R2: A mail1 store attempt while mail1_full_n=0 leaves the mail1 word unchanged and the flag low.
- R3: A clk_b edge with b_en=1, b_wr=0, b_mbx_sel=1, taken while a word is pending on the Port B side, sets mail1_full_n back to 1 no later than the third clk_a rising edge after it. Without such a read the flag stays low.
- R4: mail2 behaves the same way in the other direction. A Port B store sets mail2_full_n to 0. Stores are dropped while it is low. A Port A read (a_en=1, a_wr=0, a_mbx_sel=1) sets it back to 1 within three clk_b edges.
- R5: Port operations with the mailbox select at 0 never store into a mailbox and never release it. Such operations are queue reads and writes.
- R6: a_dout is mail2 when a_oe=1 and a_mbx_sel=1, a_fifo_q when a_oe=1 and a_mbx_sel=0, and all zeros when a_oe=0. b_dout selects mail1 or b_fifo_q in the same way, under b_oe and b_mbx_sel.
- R7: While rst1_n=0, mail1_full_n=1 and the mail1 word is 0, and mail2 is not affected. While rst2_n=0, the same holds for mail2_full_n and the mail2 word.
- R8: After a release, the next store into the same mailbox is accepted and replaces the word. Repeated round trips deliver every word in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst1_n | input | 1 | Reset of the A-to-B queue; covers mail1 (active low) |
| rst2_n | input | 1 | Reset of the B-to-A queue; covers mail2 (active low) |
| a_en | input | 1 | Port A operation enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbx_sel | input | 1 | Port A mailbox select |
| a_oe | input | 1 | Port A output enable |
| a_din | input | 36 | Port A write data |
| a_fifo_q | input | 36 | Output word of the B-to-A queue |
| a_dout | output | 36 | Port A read data |
| mail1_full_n | output | 1 | mail1 full flag, active low, clk_a domain |
| b_en | input | 1 | Port B operation enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mbx_sel | input | 1 | Port B mailbox select |
| b_oe | input | 1 | Port B output enable |
| b_din | input | 36 | Port B write data |
| b_fifo_q | input | 36 | Output word of the A-to-B queue |
| b_dout | output | 36 | Port B read data |
| mail2_full_n | output | 1 | mail2 full flag, active low, clk_b domain |

## Verification
Round trips are run on both mailboxes with seeded random words. Each trip includes a second store that arrives while the mailbox is full, so a dropped store can be told apart from an overwrite. Queue-side reads and writes with the select low are placed between the store and the release, which separates a mailbox read from a queue read. The selectors are driven with random enable, select and queue words and compared to a bench function. This shows whether each of the three sources is routed correctly. A reset of one queue while both mailboxes are full shows that each reset clears only its own mailbox, and a trip after the reset shows that the channel state was cleared.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {
        W_OPEN = 1'b0,
        W_HELD = 1'b1
    } wr_state_t;

    typedef enum logic {
        R_DRY    = 1'b0,
        R_LOADED = 1'b1
    } rd_state_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[gi] <= 1'b0;
                else if (gi == 0)
                    chain[gi] <= d;
                else
                    chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_writer.sv
module mbx_writer
    import mbx_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] din,
    input  logic          ack_tog,
    output logic          tog,
    output logic          full_n,
    output logic [DW-1:0] word
);
    wr_state_t state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= W_OPEN;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            W_OPEN: if (wr_req)         state_nx = W_HELD;
            W_HELD: if (ack_tog == tog) state_nx = W_OPEN;
        endcase
    end

    // outputs: toggle and stored word change only on an accepted store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog  <= 1'b0;
            word <= '0;
        end else if (state == W_OPEN && wr_req) begin
            tog  <= ~tog;
            word <= din;
        end
    end

    always_comb full_n = (state == W_OPEN);
endmodule

// File: rtl/mbx_reader.sv
module mbx_reader
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_tog,
    output logic tog
);
    rd_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= R_DRY;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            R_DRY:    if (wr_tog != tog) state_nx = R_LOADED;
            R_LOADED: if (rd_req)        state_nx = R_DRY;
        endcase
    end

    // output: the read toggle flips only when a pending word is taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tog <= 1'b0;
        else if (state == R_LOADED && rd_req)
            tog <= ~tog;
    end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int DW          = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] din,
    input  logic          rd_req,
    output logic          full_n,
    output logic [DW-1:0] word
);
    logic wr_tog, wr_tog_s, rd_tog, rd_tog_s;

    mbx_writer #(.DW(DW)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_req(wr_req), .din(din),
        .ack_tog(rd_tog_s), .tog(wr_tog), .full_n(full_n), .word(word)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_to_rd (
        .clk(rd_clk), .rst_n(rst_n), .d(wr_tog), .q(wr_tog_s)
    );

    mbx_reader u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_req(rd_req),
        .wr_tog(wr_tog_s), .tog(rd_tog)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_to_wr (
        .clk(wr_clk), .rst_n(rst_n), .d(rd_tog), .q(rd_tog_s)
    );
endmodule

// File: rtl/mbx_port_mux.sv
module mbx_port_mux #(
    parameter int DW = 36
) (
    input  logic          oe,
    input  logic          sel,
    input  logic [DW-1:0] mbx_word,
    input  logic [DW-1:0] fifo_word,
    output logic [DW-1:0] dout
);
    always_comb begin
        unique case ({oe, sel})
            2'b11:   dout = mbx_word;
            2'b10:   dout = fifo_word;
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/mailbox_pair.sv
module mailbox_pair #(
    parameter int DW          = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_a,
    input  logic          clk_b,
    input  logic          rst1_n,
    input  logic          rst2_n,
    input  logic          a_en,
    input  logic          a_wr,
    input  logic          a_mbx_sel,
    input  logic          a_oe,
    input  logic [DW-1:0] a_din,
    input  logic [DW-1:0] a_fifo_q,
    output logic [DW-1:0] a_dout,
    output logic          mail1_full_n,
    input  logic          b_en,
    input  logic          b_wr,
    input  logic          b_mbx_sel,
    input  logic          b_oe,
    input  logic [DW-1:0] b_din,
    input  logic [DW-1:0] b_fifo_q,
    output logic [DW-1:0] b_dout,
    output logic          mail2_full_n
);
    logic          a_mbx_wr, a_mbx_rd, b_mbx_wr, b_mbx_rd;
    logic [DW-1:0] mail1_q, mail2_q;

    assign a_mbx_wr = a_en &  a_wr & a_mbx_sel;
    assign a_mbx_rd = a_en & ~a_wr & a_mbx_sel;
    assign b_mbx_wr = b_en &  b_wr & b_mbx_sel;
    assign b_mbx_rd = b_en & ~b_wr & b_mbx_sel;

    // mail1: A stores, B reads
    mbx_channel #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_mail1 (
        .wr_clk(clk_a), .rd_clk(clk_b), .rst_n(rst1_n),
        .wr_req(a_mbx_wr), .din(a_din), .rd_req(b_mbx_rd),
        .full_n(mail1_full_n), .word(mail1_q)
    );

    // mail2: B stores, A reads
    mbx_channel #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_mail2 (
        .wr_clk(clk_b), .rd_clk(clk_a), .rst_n(rst2_n),
        .wr_req(b_mbx_wr), .din(b_din), .rd_req(a_mbx_rd),
        .full_n(mail2_full_n), .word(mail2_q)
    );

    mbx_port_mux #(.DW(DW)) u_amux (
        .oe(a_oe), .sel(a_mbx_sel), .mbx_word(mail2_q),
        .fifo_word(a_fifo_q), .dout(a_dout)
    );

    mbx_port_mux #(.DW(DW)) u_bmux (
        .oe(b_oe), .sel(b_mbx_sel), .mbx_word(mail1_q),
        .fifo_word(b_fifo_q), .dout(b_dout)
    );
endmodule

// File: rtl/mailbox_pair_chk.sv
module mailbox_pair_chk #(
    parameter int DW = 36
) (
    input logic          clk_a,
    input logic          clk_b,
    input logic          rst1_n,
    input logic          rst2_n,
    input logic          a_en,
    input logic          a_wr,
    input logic          a_mbx_sel,
    input logic          a_oe,
    input logic [DW-1:0] a_din,
    input logic [DW-1:0] a_dout,
    input logic          mail1_full_n,
    input logic          b_en,
    input logic          b_wr,
    input logic          b_mbx_sel,
    input logic [DW-1:0] b_din,
    input logic          mail2_full_n,
    input logic [DW-1:0] mail1_q,
    input logic [DW-1:0] mail2_q
);
    // R1
    a_r1_store_mail1: assert property (@(posedge clk_a) disable iff (!rst1_n)
        (a_en && a_wr && a_mbx_sel && mail1_full_n) |=> (!mail1_full_n && mail1_q == $past(a_din)));
    a_r1_store_mail2: assert property (@(posedge clk_b) disable iff (!rst2_n)
        (b_en && b_wr && b_mbx_sel && mail2_full_n) |=> (!mail2_full_n && mail2_q == $past(b_din)));
    // R2
    a_r2_full_mail1_holds: assert property (@(posedge clk_a) disable iff (!rst1_n)
        (!mail1_full_n) |=> $stable(mail1_q));
    // R4
    a_r4_full_mail2_holds: assert property (@(posedge clk_b) disable iff (!rst2_n)
        (!mail2_full_n) |=> $stable(mail2_q));
    // R5
    a_r5_no_store_without_sel: assert property (@(posedge clk_a) disable iff (!rst1_n)
        (mail1_full_n && !(a_en && a_wr && a_mbx_sel)) |=> mail1_full_n);
    // R6
    a_r6_amux_mail: assert property (@(posedge clk_a) disable iff (!rst2_n)
        (a_oe && a_mbx_sel) |-> (a_dout == mail2_q));
    a_r6_amux_off: assert property (@(posedge clk_a) disable iff (!rst2_n)
        (!a_oe) |-> (a_dout == '0));
    // R7
    a_r7_reset_mail1: assert property (@(posedge clk_a)
        (!rst1_n) |-> (mail1_full_n && mail1_q == '0));
    a_r7_reset_mail2: assert property (@(posedge clk_b)
        (!rst2_n) |-> (mail2_full_n && mail2_q == '0));
endmodule

bind mailbox_pair mailbox_pair_chk #(.DW(DW)) u_chk (
    .clk_a(clk_a), .clk_b(clk_b), .rst1_n(rst1_n), .rst2_n(rst2_n),
    .a_en(a_en), .a_wr(a_wr), .a_mbx_sel(a_mbx_sel), .a_oe(a_oe),
    .a_din(a_din), .a_dout(a_dout), .mail1_full_n(mail1_full_n),
    .b_en(b_en), .b_wr(b_wr), .b_mbx_sel(b_mbx_sel), .b_din(b_din),
    .mail2_full_n(mail2_full_n), .mail1_q(mail1_q), .mail2_q(mail2_q)
);

// File: tb/mailbox_pair_tb.sv
module mailbox_pair_tb;
    localparam int DW = 36;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst1_n = 1'b0, rst2_n = 1'b0;
    logic a_en = 0, a_wr = 0, a_mbx_sel = 0, a_oe = 0;
    logic b_en = 0, b_wr = 0, b_mbx_sel = 0, b_oe = 0;
    logic [DW-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
    logic [DW-1:0] a_dout, b_dout;
    logic mail1_full_n, mail2_full_n;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [DW-1:0] exp_m1 = '0, exp_m2 = '0;

    always #2.5 clk_a = ~clk_a;   // 200 MHz
    always #3.5 clk_b = ~clk_b;   // unrelated Port B clock

    mailbox_pair #(.DW(DW)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mux_exp(input logic oe, input logic sel,
                                              input logic [DW-1:0] mbx, input logic [DW-1:0] fifo);
        if (!oe) return '0;
        return sel ? mbx : fifo;
    endfunction

    function automatic logic [DW-1:0] rnd36();
        return {4'($urandom()), 32'($urandom())};
    endfunction

    task automatic a_op(input logic wr, input logic sel, input logic [DW-1:0] d);
        @(negedge clk_a); a_en = 1; a_wr = wr; a_mbx_sel = sel; a_din = d;
        @(negedge clk_a); a_en = 0; a_wr = 0; a_din = '0;
    endtask

    task automatic b_op(input logic wr, input logic sel, input logic [DW-1:0] d);
        @(negedge clk_b); b_en = 1; b_wr = wr; b_mbx_sel = sel; b_din = d;
        @(negedge clk_b); b_en = 0; b_wr = 0; b_din = '0;
    endtask

    task automatic view_b_mail1(output logic [DW-1:0] v);
        b_oe = 1; b_mbx_sel = 1; #0.2; v = b_dout;
    endtask

    task automatic view_a_mail2(output logic [DW-1:0] v);
        a_oe = 1; a_mbx_sel = 1; #0.2; v = a_dout;
    endtask

    task automatic mail1_trip(input logic [DW-1:0] d, input logic [DW-1:0] d2);
        logic [DW-1:0] v;
        a_op(1, 1, d); exp_m1 = d;
        chk(mail1_full_n == 1'b0, "R1 mail1 flag low after store", DW'(mail1_full_n), '0);
        view_b_mail1(v);
        chk(v == exp_m1, "R1 mail1 word", v, exp_m1);
        a_op(1, 1, d2);                       // dropped: mailbox full
        view_b_mail1(v);
        chk(v == exp_m1, "R2 blocked store left word", v, exp_m1);
        a_op(1, 0, d2);                       // queue write, sel low
        b_op(0, 0, '0);                       // queue read, sel low
        repeat (6) @(negedge clk_a);
        chk(mail1_full_n == 1'b0, "R5/R3 flag stays low without mailbox read", DW'(mail1_full_n), '0);
        b_op(0, 1, '0);                       // mailbox read
        repeat (4) @(negedge clk_a);
        chk(mail1_full_n == 1'b1, "R3 mail1 released", DW'(mail1_full_n), 1);
        a_op(1, 1, d2); exp_m1 = d2;
        view_b_mail1(v);
        chk(v == exp_m1 && !mail1_full_n, "R8 next store accepted", v, exp_m1);
        repeat (4) @(negedge clk_b);
        b_op(0, 1, '0);
        repeat (4) @(negedge clk_a);
        chk(mail1_full_n == 1'b1, "R8 second release", DW'(mail1_full_n), 1);
    endtask

    task automatic mail2_trip(input logic [DW-1:0] d, input logic [DW-1:0] d2);
        logic [DW-1:0] v;
        b_op(1, 1, d); exp_m2 = d;
        chk(mail2_full_n == 1'b0, "R4 mail2 flag low after store", DW'(mail2_full_n), '0);
        view_a_mail2(v);
        chk(v == exp_m2, "R4 mail2 word", v, exp_m2);
        b_op(1, 1, d2);
        view_a_mail2(v);
        chk(v == exp_m2, "R4 blocked store left word", v, exp_m2);
        b_op(1, 0, d2);
        a_op(0, 0, '0);
        repeat (6) @(negedge clk_b);
        chk(mail2_full_n == 1'b0, "R5 mail2 stays low without mailbox read", DW'(mail2_full_n), '0);
        a_op(0, 1, '0);
        repeat (4) @(negedge clk_b);
        chk(mail2_full_n == 1'b1, "R4 mail2 released", DW'(mail2_full_n), 1);
    endtask

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk_b);
        rst1_n = 1; rst2_n = 1;
        @(negedge clk_a);
        // R7 reset state
        chk(mail1_full_n && mail2_full_n, "R7 flags high after reset", DW'({mail1_full_n, mail2_full_n}), 3);
        view_b_mail1(v); chk(v == '0, "R7 mail1 word zero", v, '0);
        view_a_mail2(v); chk(v == '0, "R7 mail2 word zero", v, '0);

        // directed round trips, then random
        mail1_trip(36'hF_0000_0001, 36'h0_FFFF_FFFE);
        mail2_trip(36'hA_5A5A_5A5A, 36'h5_A5A5_A5A5);
        for (int i = 0; i < 15; i++) begin
            mail1_trip(rnd36(), rnd36());
            mail2_trip(rnd36(), rnd36());
        end

        // R6 selector with random controls
        for (int i = 0; i < 40; i++) begin
            logic ao, as, bo, bs;
            ao = 1'($urandom()); as = 1'($urandom());
            bo = 1'($urandom()); bs = 1'($urandom());
            a_oe = ao; a_mbx_sel = as; b_oe = bo; b_mbx_sel = bs;
            a_fifo_q = rnd36(); b_fifo_q = rnd36();
            #1;
            chk(a_dout == mux_exp(ao, as, exp_m2, a_fifo_q), "R6 port A selector", a_dout, mux_exp(ao, as, exp_m2, a_fifo_q));
            chk(b_dout == mux_exp(bo, bs, exp_m1, b_fifo_q), "R6 port B selector", b_dout, mux_exp(bo, bs, exp_m1, b_fifo_q));
        end

        // R7 reset isolation with both mailboxes full
        a_op(1, 1, 36'h1_2345_6789); exp_m1 = 36'h1_2345_6789;
        b_op(1, 1, 36'h9_8765_4321); exp_m2 = 36'h9_8765_4321;
        @(negedge clk_a); rst1_n = 0;
        repeat (3) @(negedge clk_b);
        @(negedge clk_a); rst1_n = 1; exp_m1 = '0;
        chk(mail1_full_n == 1'b1, "R7 rst1 frees mail1", DW'(mail1_full_n), 1);
        view_b_mail1(v); chk(v == '0, "R7 rst1 clears mail1", v, '0);
        chk(mail2_full_n == 1'b0, "R7 rst1 spares mail2 flag", DW'(mail2_full_n), '0);
        view_a_mail2(v); chk(v == exp_m2, "R7 rst1 spares mail2 word", v, exp_m2);
        @(negedge clk_b); rst2_n = 0;
        repeat (3) @(negedge clk_a);
        @(negedge clk_b); rst2_n = 1; exp_m2 = '0;
        chk(mail2_full_n == 1'b1, "R7 rst2 frees mail2", DW'(mail2_full_n), 1);
        view_a_mail2(v); chk(v == '0, "R7 rst2 clears mail2", v, '0);
        mail1_trip(36'h3_3333_3333, 36'hC_CCCC_CCCC);
        mail2_trip(36'h7_0F0F_0F0F, 36'h8_F0F0_F0F0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule